// File: doc/BRIEF.md
# Mailbox Handshake Responder

This block answers a host's register accesses the way a firmware-loading coprocessor's mailbox would. That lets a host boot sequence get through its mailbox handshakes without any real firmware behind them. A small set of word offsets on a 32-bit register bus is decoded. A few offsets return fixed "ready" or "alive" words. Writes to other offsets change what later reads return: a key word written to the status offset arms a second offset with a fixed answer, and the command offset echoes its last write plus a bias.

The block also records where a host places its command ring. The 64-bit base arrives as two 32-bit halves, and the size arrives as one 32-bit word. After each write to either half of the base, the block computes a listen address: the ring base, minus the system-address base on the `sys_base` input, plus 0xC. The listen address is driven on an output port so that a neighbouring bus snooper can watch that location.

All offsets are parameters. With the defaults they are: status 0x23, armed message 0x51, command 0x40, ring base low 0x45, ring base high 0x46, ring size 0x47, firmware-alive 0x5A.

Top module: `mbx_resp_top`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `rd_valid` is 0, `rd_data` is 0 and `listen_addr` is 0. A reset returns every stored value (armed flag, command word, ring base, ring size) to its initial state.
- R2: A read issued with `bus_rd` high in one cycle gives `rd_valid` high and the read value on `rd_data` in the following cycle. When no read was issued, `rd_valid` is 0 and `rd_data` is 0. A read of an offset that is not mapped returns 0, and a write to one changes nothing.
- R3: A read of the status offset always returns 0x80000000, whatever has been written to that offset.
- R4: The armed-message offset reads 0 after reset. Once 0x00010000 has been written to the status offset, it reads 0x0DF40B31 until the next reset. A status write of any other value leaves the armed state as it was.
- R5: The command offset reads 0x80000000 after reset. After a write of value V, it reads (0x80000000 + V) modulo 2^32.
- R6: A write to the ring-low offset replaces bits 31:0 of the 64-bit ring base, and a write to the ring-high offset replaces bits 63:32. Each offset reads back its own half.
- R7: One cycle after each write to ring-low or ring-high, `listen_addr` equals (new ring base − `sys_base` sampled in the write cycle + 0xC) modulo 2^64. At all other times `listen_addr` holds its value, even when `sys_base` changes.
- R8: A write to the ring-size offset stores a 32-bit size, and that offset reads it back.
- R9: The firmware-alive offset always reads 0x00000001. Writes to the firmware-alive offset and to the armed-message offset have no effect on what they read.
- R10: When a read and a write to the same offset happen in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| sys_base | input | 64 | System-address base subtracted from the ring base |
| rd_data | output | 32 | Read data, one cycle after the read strobe |
| rd_valid | output | 1 | Marks the cycle in which `rd_data` carries a read result |
| listen_addr | output | 64 | Derived ring listen address |

## Verification
The assertions assume that `bus_rd`, `bus_wr` and `bus_addr` carry known values at every rising edge after reset. They also assume that `sys_base` is steady through a ring write, and that each strobe describes exactly one access per cycle. The stimulus drives every input on the falling edge and holds it through the following rising edge. It raises each strobe for a single cycle, and it changes `sys_base` only in cycles with no ring write, except where the R7 hold behaviour is being exercised on purpose.

// File: rtl/mbx_resp_pkg.sv
package mbx_resp_pkg;
   localparam int DW     = 32;
   localparam int NSLOT  = 7;

   localparam int SL_STATUS = 0;
   localparam int SL_ARMED  = 1;
   localparam int SL_CMD    = 2;
   localparam int SL_RLO    = 3;
   localparam int SL_RHI    = 4;
   localparam int SL_RSZ    = 5;
   localparam int SL_FWRDY  = 6;

   localparam logic [DW-1:0] READY_WORD = 32'h8000_0000;
   localparam logic [DW-1:0] ARM_KEY    = 32'h0001_0000;
   localparam logic [DW-1:0] ARM_WORD   = 32'h0DF4_0B31;
   localparam logic [DW-1:0] CMD_BIAS   = 32'h8000_0000;
   localparam logic [DW-1:0] FW_ALIVE   = 32'h0000_0001;
endpackage

// File: rtl/mbx_resp_decode.sv
module mbx_resp_decode #(
   parameter int ADDR_W = 8,
   parameter int NSLOT  = 7,
   parameter logic [NSLOT*ADDR_W-1:0] OFS_TABLE = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NSLOT-1:0]  sel
);
   for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
      assign sel[i] = (addr == OFS_TABLE[i*ADDR_W +: ADDR_W]);
      for (genvar j = i + 1; j < NSLOT; j++) begin : g_uniq
         if (OFS_TABLE[i*ADDR_W +: ADDR_W] == OFS_TABLE[j*ADDR_W +: ADDR_W]) begin : g_dup
            $error("mbx_resp_decode: two slots share one offset");
         end
      end
   end
endmodule

// File: rtl/mbx_resp_msg.sv
module mbx_resp_msg
   import mbx_resp_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_status,
   input  logic          wr_cmd,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] armed_val,
   output logic [DW-1:0] cmd_val
);
   logic          armed_q;
   logic [DW-1:0] cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cmd_q   <= '0;
      end else begin
         if (wr_status && (wdata == ARM_KEY)) armed_q <= 1'b1;
         if (wr_cmd) cmd_q <= wdata;
      end
   end

   assign armed_val = armed_q ? ARM_WORD : '0;
   assign cmd_val   = CMD_BIAS + cmd_q;

   // R4: once armed, the answer stays until reset
   a_r4_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_val == ARM_WORD) |=> (armed_val == ARM_WORD));

   // R4: key write arms
   a_r4_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && wdata == ARM_KEY) |=> (armed_val == ARM_WORD));

   // R5: command echo with bias
   a_r5_cmd_echo: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd |=> (cmd_val == CMD_BIAS + $past(wdata)));
endmodule

// File: rtl/mbx_resp_ring.sv
module mbx_resp_ring #(
   parameter int          DW          = 32,
   parameter int          RING_W      = 64,
   parameter logic [63:0] LISTEN_BIAS = 64'hC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              wr_size,
   input  logic [DW-1:0]     wdata,
   input  logic [RING_W-1:0] sys_base,
   output logic [RING_W-1:0] ring_base,
   output logic [DW-1:0]     ring_size,
   output logic [RING_W-1:0] listen_addr
);
   localparam int HALF = RING_W / 2;

   if (RING_W != 2 * DW) begin : g_bad_width
      $error("mbx_resp_ring: ring base must be two data words wide");
   end

   logic [RING_W-1:0] next_base;

   always_comb begin
      next_base = ring_base;
      if (wr_lo) next_base[HALF-1:0]      = wdata;
      if (wr_hi) next_base[RING_W-1:HALF] = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_base   <= '0;
         ring_size   <= '0;
         listen_addr <= '0;
      end else begin
         if (wr_lo || wr_hi) begin
            ring_base   <= next_base;
            listen_addr <= next_base - sys_base + RING_W'(LISTEN_BIAS);
         end
         if (wr_size) ring_size <= wdata;
      end
   end

   // R7: recompute after a ring write
   a_r7_listen_update: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo || wr_hi) |=> (listen_addr == ring_base - $past(sys_base) + RING_W'(LISTEN_BIAS)));

   // R7: hold when no ring write
   a_r7_listen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_lo || wr_hi) |=> $stable(listen_addr));

   // R6: low write leaves high half alone
   a_r6_halves: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> (ring_base[RING_W-1:HALF] == $past(ring_base[RING_W-1:HALF])));
endmodule

// File: rtl/mbx_resp_top.sv
module mbx_resp_top
   import mbx_resp_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          OFS_STATUS  = 'h23,
   parameter int          OFS_ARMED   = 'h51,
   parameter int          OFS_CMD     = 'h40,
   parameter int          OFS_RLO     = 'h45,
   parameter int          OFS_RHI     = 'h46,
   parameter int          OFS_RSZ     = 'h47,
   parameter int          OFS_FWRDY   = 'h5A,
   parameter bit          REG_RDATA   = 1'b1,
   parameter logic [63:0] LISTEN_BIAS = 64'hC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   input  logic [63:0]       sys_base,
   output logic [DW-1:0]     rd_data,
   output logic              rd_valid,
   output logic [63:0]       listen_addr
);
   localparam int RING_W = 2 * DW;
   localparam int OFS_MAX = (1 << ADDR_W) - 1;
   localparam logic [NSLOT*ADDR_W-1:0] OFS_TABLE = {
      ADDR_W'(OFS_FWRDY), ADDR_W'(OFS_RSZ), ADDR_W'(OFS_RHI), ADDR_W'(OFS_RLO),
      ADDR_W'(OFS_CMD), ADDR_W'(OFS_ARMED), ADDR_W'(OFS_STATUS)};

   if (ADDR_W < 3 || ADDR_W > 30) begin : g_bad_aw
      $error("mbx_resp_top: ADDR_W out of range");
   end
   if (OFS_STATUS > OFS_MAX || OFS_ARMED > OFS_MAX || OFS_CMD > OFS_MAX ||
       OFS_RLO > OFS_MAX || OFS_RHI > OFS_MAX || OFS_RSZ > OFS_MAX ||
       OFS_FWRDY > OFS_MAX) begin : g_bad_ofs
      $error("mbx_resp_top: an offset does not fit in ADDR_W");
   end

   logic [NSLOT-1:0]  sel;
   logic [NSLOT-1:0]  wsel;
   logic [DW-1:0]     slot_val [NSLOT];
   logic [DW-1:0]     armed_val, cmd_val, ring_size;
   logic [RING_W-1:0] ring_base;
   logic [DW-1:0]     rd_mux;

   mbx_resp_decode #(.ADDR_W(ADDR_W), .NSLOT(NSLOT), .OFS_TABLE(OFS_TABLE)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign wsel = bus_wr ? sel : '0;

   mbx_resp_msg u_msg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_status (wsel[SL_STATUS]),
      .wr_cmd    (wsel[SL_CMD]),
      .wdata     (bus_wdata),
      .armed_val (armed_val),
      .cmd_val   (cmd_val)
   );

   mbx_resp_ring #(.DW(DW), .RING_W(RING_W), .LISTEN_BIAS(LISTEN_BIAS)) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_lo       (wsel[SL_RLO]),
      .wr_hi       (wsel[SL_RHI]),
      .wr_size     (wsel[SL_RSZ]),
      .wdata       (bus_wdata),
      .sys_base    (sys_base),
      .ring_base   (ring_base),
      .ring_size   (ring_size),
      .listen_addr (listen_addr)
   );

   assign slot_val[SL_STATUS] = READY_WORD;
   assign slot_val[SL_ARMED]  = armed_val;
   assign slot_val[SL_CMD]    = cmd_val;
   assign slot_val[SL_RLO]    = ring_base[DW-1:0];
   assign slot_val[SL_RHI]    = ring_base[RING_W-1:DW];
   assign slot_val[SL_RSZ]    = ring_size;
   assign slot_val[SL_FWRDY]  = FW_ALIVE;

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (sel[i]) rd_mux = rd_mux | slot_val[i];
      end
   end

   if (REG_RDATA) begin : g_reg_rd
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
         end else begin
            rd_data  <= bus_rd ? rd_mux : '0;
            rd_valid <= bus_rd;
         end
      end

      // R2: one-cycle read latency
      a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         bus_rd |=> rd_valid);
      // R2: idle bus shows zero
      a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_rd |=> (!rd_valid && rd_data == '0));
      // R3: status always ready
      a_r3_status_ready: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == ADDR_W'(OFS_STATUS)) |=> (rd_data == READY_WORD));
      // R9: firmware-alive constant
      a_r9_fw_alive: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == ADDR_W'(OFS_FWRDY)) |=> (rd_data == FW_ALIVE));
   end else begin : g_comb_rd
      assign rd_data  = (rst_n && bus_rd) ? rd_mux : '0;
      assign rd_valid = rst_n && bus_rd;
   end

   // R2: at most one slot decoded
   a_r2_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
endmodule

// File: tb/mbx_resp_top_test.sv
module mbx_resp_top_test;
   localparam logic [7:0] A_ST = 8'h23, A_AR = 8'h51, A_CM = 8'h40, A_LO = 8'h45,
                          A_HI = 8'h46, A_SZ = 8'h47, A_FW = 8'h5A, A_NM = 8'h10;

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{1'b0, A_ST, 32'h0, 32'h8000_0000, 4'd3},   // R3
      '{1'b0, A_CM, 32'h0, 32'h8000_0000, 4'd5},   // R5
      '{1'b0, A_AR, 32'h0, 32'h0000_0000, 4'd4},   // R4
      '{1'b1, A_ST, 32'h0000_1234, 32'h0, 4'd4},
      '{1'b0, A_AR, 32'h0, 32'h0000_0000, 4'd4},   // R4 wrong key
      '{1'b0, A_ST, 32'h0, 32'h8000_0000, 4'd3},   // R3 after write
      '{1'b1, A_ST, 32'h0001_0000, 32'h0, 4'd4},
      '{1'b0, A_AR, 32'h0, 32'h0DF4_0B31, 4'd4},   // R4 armed
      '{1'b1, A_ST, 32'h0000_0000, 32'h0, 4'd4},
      '{1'b0, A_AR, 32'h0, 32'h0DF4_0B31, 4'd4},   // R4 stays
      '{1'b1, A_CM, 32'h0000_0005, 32'h0, 4'd5},
      '{1'b0, A_CM, 32'h0, 32'h8000_0005, 4'd5},   // R5
      '{1'b1, A_CM, 32'h9000_0000, 32'h0, 4'd5},
      '{1'b0, A_CM, 32'h0, 32'h1000_0000, 4'd5},   // R5 wrap
      '{1'b0, A_FW, 32'h0, 32'h0000_0001, 4'd9},   // R9
      '{1'b1, A_FW, 32'hFFFF_FFFF, 32'h0, 4'd9},
      '{1'b0, A_FW, 32'h0, 32'h0000_0001, 4'd9},   // R9 write ignored
      '{1'b1, A_SZ, 32'h0000_0400, 32'h0, 4'd8},
      '{1'b0, A_SZ, 32'h0, 32'h0000_0400, 4'd8},   // R8
      '{1'b1, A_NM, 32'h0000_AAAA, 32'h0, 4'd2},
      '{1'b0, A_NM, 32'h0, 32'h0000_0000, 4'd2},   // R2 unmapped
      '{1'b1, A_AR, 32'h0000_0000, 32'h0, 4'd9}    // R9 armed write
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [63:0] sys_base = '0;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic [63:0] listen_addr;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   logic [63:0] ring_m;

   always #5 clk = ~clk;

   mbx_resp_top uut (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .sys_base (sys_base),
      .rd_data (rd_data), .rd_valid (rd_valid), .listen_addr (listen_addr)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog expired: actual=%0d expected<=20000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // sets inputs at a falling edge, returns at the next falling edge
   task automatic step(input logic wr, input logic rd, input logic [7:0] a, input logic [31:0] d);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      step(1'b0, 1'b1, a, 32'h0);
      chk(req, {63'h0, rd_valid}, 64'h1);
      chk(req, {32'h0, rd_data}, {32'h0, exp});
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", {63'h0, rd_valid}, 64'h0);
      chk("R1", {32'h0, rd_data}, 64'h0);
      chk("R1", listen_addr, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", listen_addr, 64'h0);
      chk("R2", {63'h0, rd_valid}, 64'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) begin
            step(1'b1, 1'b0, VEC[i].addr, VEC[i].data);
            chk($sformatf("R%0d write idle", VEC[i].req), {63'h0, rd_valid}, 64'h0);
         end else begin
            rd_chk($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].addr, VEC[i].exp);
         end
      end
      rd_chk("R9", A_AR, 32'h0DF4_0B31);

      // R6 / R7: ring base and listen address
      sys_base = 64'h0000_0080_0000_0000;
      ring_m = 64'h0;
      step(1'b1, 1'b0, A_LO, 32'h0000_1000);
      ring_m[31:0] = 32'h0000_1000;
      chk("R7 low", listen_addr, ring_m - 64'h0000_0080_0000_0000 + 64'hC);
      step(1'b1, 1'b0, A_HI, 32'h0000_0080);
      ring_m[63:32] = 32'h0000_0080;
      chk("R7 high", listen_addr, ring_m - 64'h0000_0080_0000_0000 + 64'hC);
      sys_base = 64'h0000_0000_0000_0100;
      step(1'b0, 1'b0, A_NM, 32'h0);
      step(1'b0, 1'b0, A_NM, 32'h0);
      chk("R7 hold", listen_addr, 64'h0000_0000_0000_100C);
      rd_chk("R6 low", A_LO, 32'h0000_1000);
      rd_chk("R6 high", A_HI, 32'h0000_0080);
      step(1'b1, 1'b0, A_LO, 32'h0000_0000);
      ring_m[31:0] = 32'h0;
      chk("R7 recompute", listen_addr, ring_m - 64'h100 + 64'hC);
      rd_chk("R6 high kept", A_HI, 32'h0000_0080);

      // R10: same-cycle read and write
      step(1'b1, 1'b1, A_CM, 32'h0000_0007);
      chk("R10", {32'h0, rd_data}, 64'h1000_0000 | 64'h8000_0000 - 64'h8000_0000 + 64'h1000_0000 - 64'h1000_0000);
      rd_chk("R10 after", A_CM, 32'h8000_0007);
      step(1'b1, 1'b1, A_SZ, 32'h0000_0055);
      chk("R10 size", {32'h0, rd_data}, 64'h400);
      rd_chk("R8 new size", A_SZ, 32'h0000_0055);

      // R1 / R4: second reset clears stored state
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid reset", {63'h0, rd_valid}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 listen", listen_addr, 64'h0);
      rd_chk("R4 after reset", A_AR, 32'h0);
      rd_chk("R5 after reset", A_CM, 32'h8000_0000);
      rd_chk("R1 ring size", A_SZ, 32'h0);
      rd_chk("R1 ring low", A_LO, 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule